// File: doc/BRIEF.md
# Two-Candidate Row Decoder for Summed Cache Index

This block lets a cache index lookup begin before the base-plus-offset addition is finished. The index field of each operand is split three ways: byte offset at the bottom, column bits above it, row bits at the top. The block adds only the short row fields. It decodes two neighbouring rows in parallel, one for an incoming carry of 0 and one for an incoming carry of 1, and reads both rows from a small internal register array.

The carry out of the lower part of the addition (byte offset plus column bits) arrives late. It selects which decoded row and which fetched line survive. The column bits from that same lower addition then pick one word out of the chosen line.

The row select, column select and word are registered. They appear one cycle after the request strobe. The array contents are fixed at reset by a formula, so every lookup has a known answer. The row/column split is set by parameters, so bits can be moved from the row path into the column multiplexer.

Top module: `sad_row_lookup`

## Requirements
- R1: The index field is laid out as byte offset in bits [OFF_W-1:0], column in the next COL_W bits and row in the top ROW_W bits. The row chosen is the row field of (base_idx + ofs_idx) taken modulo 2^(OFF_W+COL_W+ROW_W).
- R2: Whenever out_vld is 1, row_sel has exactly one bit set, at the position of the chosen row.
- R3: A carry out of the byte-offset plus column addition moves the chosen row one above the sum of the two row fields.
- R4: Row candidates wrap modulo the row count, so a carry out of the last row selects row 0.
- R5: col_sel equals the column field of the full sum, including any carry out of the byte-offset bits.
- R6: rd_data equals the array word at (row, column). After reset, the word at row r and column c holds the low DATA_W bits of (r*2^COL_W + c)*37 + 5.
- R7: out_vld is 1 exactly one cycle after a cycle with req_vld high, and the results of that request appear in the same cycle.
- R8: In a cycle following one with req_vld low, out_vld and row_sel are 0, and col_sel and rd_data keep their previous values.
- R9: Synchronous active-high reset clears out_vld, row_sel, col_sel and rd_data to 0.
- R10: Byte-offset bits affect the outputs only through the carry they produce: changing them without changing that carry leaves row_sel, col_sel and rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Lookup request strobe |
| base_idx | input | OFF_W+COL_W+ROW_W | Index field of the base operand |
| ofs_idx | input | OFF_W+COL_W+ROW_W | Index field of the offset operand |
| out_vld | output | 1 | Registered result valid |
| row_sel | output | 2^ROW_W | One-hot row selected |
| col_sel | output | COL_W | Column (word within row) selected |
| rd_data | output | DATA_W | Word read from the chosen row and column |

## Verification
The assertions assume that req_vld and both index operands are driven to known values from the first clock edge on. They also assume that reset lasts at least one edge, so that the array is loaded before a request. The bench drives every input at the falling edge, holds reset with all inputs at zero, and issues requests only after reset is released. Operand patterns are chosen to hit no carry, a carry out of the byte bits rippling through the column bits, wrap past the last row, back-to-back requests and idle gaps. A pseudo-random sweep follows, checked against a full-width addition.

// File: rtl/sad_pkg.sv
package sad_pkg;

    // Contents of the lookup array are generated, not stored as a table.
    localparam int WORD_MUL = 37;
    localparam int WORD_ADD = 5;

    typedef enum logic {
        PICK_NO_CARRY = 1'b0,
        PICK_CARRY    = 1'b1
    } carry_pick_e;

    function automatic logic [63:0] init_word(input int lin);
        return 64'(lin * WORD_MUL + WORD_ADD);
    endfunction

endpackage

// File: rtl/sad_low_add.sv
// Lower-order part of the index addition: byte offset and column bits.
// Produces the column and the carry into the row field.
module sad_low_add #(
    parameter int OFF_W = 5,
    parameter int COL_W = 2,
    localparam int LOW_W = OFF_W + COL_W
) (
    input  logic [LOW_W-1:0] a_low,
    input  logic [LOW_W-1:0] b_low,
    output logic [COL_W-1:0] col,
    output logic             row_cin
);
    logic             off_cout;
    logic [COL_W:0]   col_sum;

    // Carry out of the byte-offset bits, by comparing the widened sum.
    assign off_cout = (({1'b0, a_low[OFF_W-1:0]} + {1'b0, b_low[OFF_W-1:0]})
                       > {1'b0, {OFF_W{1'b1}}});

    assign col_sum = {1'b0, a_low[LOW_W-1:OFF_W]}
                   + {1'b0, b_low[LOW_W-1:OFF_W]}
                   + {{COL_W{1'b0}}, off_cout};

    assign col     = col_sum[COL_W-1:0];
    assign row_cin = col_sum[COL_W];
endmodule

// File: rtl/sad_row_dual_dec.sv
// Adds the two row fields and decodes both carry-in candidates at once.
module sad_row_dual_dec #(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic [ROW_W-1:0] a_row,
    input  logic [ROW_W-1:0] b_row,
    output logic [ROWS-1:0]  dec_nc,
    output logic [ROWS-1:0]  dec_c
);
    logic [ROW_W-1:0] sum_nc;
    logic [ROW_W-1:0] sum_c;

    assign sum_nc = a_row + b_row;
    assign sum_c  = a_row + b_row + ROW_W'(1);   // wraps modulo ROWS

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign dec_nc[r] = (sum_nc == ROW_W'(r));
        assign dec_c[r]  = (sum_c  == ROW_W'(r));
    end
endmodule

// File: rtl/sad_row_bank.sv
// Register array loaded at reset; reads two rows per cycle through
// one-hot AND-OR selection.
module sad_row_bank
    import sad_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 2,
    parameter int DATA_W = 16,
    localparam int ROWS   = 1 << ROW_W,
    localparam int COLS   = 1 << COL_W,
    localparam int LINE_W = COLS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROWS-1:0]   sel_nc,
    input  logic [ROWS-1:0]   sel_c,
    output logic [LINE_W-1:0] line_nc,
    output logic [LINE_W-1:0] line_c
);
    logic [LINE_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem_q[r][c*DATA_W +: DATA_W] <= DATA_W'(init_word(r * COLS + c));
                end
            end
        end
    end

    always_comb begin
        line_nc = '0;
        line_c  = '0;
        for (int r = 0; r < ROWS; r++) begin
            line_nc = line_nc | ({LINE_W{sel_nc[r]}} & mem_q[r]);
            line_c  = line_c  | ({LINE_W{sel_c[r]}}  & mem_q[r]);
        end
    end
endmodule

// File: rtl/sad_row_lookup.sv
module sad_row_lookup
    import sad_pkg::*;
#(
    parameter int OFF_W  = 5,
    parameter int COL_W  = 2,
    parameter int ROW_W  = 4,
    parameter int DATA_W = 16,
    localparam int LOW_W  = OFF_W + COL_W,
    localparam int IDX_W  = LOW_W + ROW_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int COLS   = 1 << COL_W,
    localparam int LINE_W = COLS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IDX_W-1:0]  ofs_idx,
    output logic              out_vld,
    output logic [ROWS-1:0]   row_sel,
    output logic [COL_W-1:0]  col_sel,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [ROWS-1:0]   row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
    } lookup_t;

    logic [COL_W-1:0]  col_now;
    logic              row_cin;
    logic [ROWS-1:0]   dec_nc;
    logic [ROWS-1:0]   dec_c;
    logic [LINE_W-1:0] line_nc;
    logic [LINE_W-1:0] line_c;
    logic [LINE_W-1:0] line_pick;
    carry_pick_e       pick;
    lookup_t           res_d;

    // Slow path: lower-order add yields column and row carry-in.
    sad_low_add #(.OFF_W(OFF_W), .COL_W(COL_W)) u_low (
        .a_low   (base_idx[LOW_W-1:0]),
        .b_low   (ofs_idx[LOW_W-1:0]),
        .col     (col_now),
        .row_cin (row_cin)
    );

    // Fast path: short row add, both candidates decoded.
    sad_row_dual_dec #(.ROW_W(ROW_W)) u_dec (
        .a_row  (base_idx[IDX_W-1:LOW_W]),
        .b_row  (ofs_idx[IDX_W-1:LOW_W]),
        .dec_nc (dec_nc),
        .dec_c  (dec_c)
    );

    // Both candidate rows fetched regardless of the carry.
    sad_row_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel_nc  (dec_nc),
        .sel_c   (dec_c),
        .line_nc (line_nc),
        .line_c  (line_c)
    );

    // Late select by the resolved carry, then column mux.
    assign pick = carry_pick_e'(row_cin);

    always_comb begin
        unique case (pick)
            PICK_CARRY: begin
                res_d.row = dec_c;
                line_pick = line_c;
            end
            default: begin
                res_d.row = dec_nc;
                line_pick = line_nc;
            end
        endcase
        res_d.col  = col_now;
        res_d.data = line_pick[col_now*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            row_sel <= '0;
            col_sel <= '0;
            rd_data <= '0;
        end else begin
            out_vld <= req_vld;
            if (req_vld) begin
                row_sel <= res_d.row;
                col_sel <= res_d.col;
                rd_data <= res_d.data;
            end else begin
                row_sel <= '0;
            end
        end
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($countones(row_sel) == 1)); // R2

    AST_CAND_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (dec_c == {dec_nc[ROWS-2:0], dec_nc[ROWS-1]})); // R4

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> out_vld); // R7

    AST_IDLE_ROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!out_vld && row_sel == '0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> ($stable(rd_data) && $stable(col_sel))); // R8

endmodule

// File: tb/sad_row_lookup_tb.sv
module sad_row_lookup_tb_top;
    localparam int OFF_W  = 5;
    localparam int COL_W  = 2;
    localparam int ROW_W  = 4;
    localparam int DATA_W = 16;
    localparam int LOW_W  = OFF_W + COL_W;
    localparam int IDX_W  = LOW_W + ROW_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_vld = 1'b0;
    logic [IDX_W-1:0]  base_idx = '0;
    logic [IDX_W-1:0]  ofs_idx = '0;
    logic              out_vld;
    logic [ROWS-1:0]   row_sel;
    logic [COL_W-1:0]  col_sel;
    logic [DATA_W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sad_row_lookup #(.OFF_W(OFF_W), .COL_W(COL_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .req_vld(req_vld), .base_idx(base_idx), .ofs_idx(ofs_idx),
        .out_vld(out_vld), .row_sel(row_sel), .col_sel(col_sel), .rd_data(rd_data)
    );

    function automatic logic [DATA_W-1:0] ref_word(input int r, input int c);
        return DATA_W'((r * COLS + c) * 37 + 5);
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one request and check against a full-width reference addition.
    task automatic do_lookup(input logic [IDX_W-1:0] b, input logic [IDX_W-1:0] o, input string req);
        logic [IDX_W-1:0] full;
        int r, c;
        full = b + o;
        r = int'(full[IDX_W-1:LOW_W]);
        c = int'(full[LOW_W-1:OFF_W]);
        @(negedge clk);
        base_idx = b;
        ofs_idx  = o;
        req_vld  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_vld = 1'b0;
        check(req, "out_vld (R7)", longint'(out_vld), 1);
        check(req, "row_sel (R1 R2)", longint'(row_sel), longint'(ROWS'(1) << r));
        check(req, "col_sel (R5)", longint'(col_sel), longint'(c));
        check(req, "rd_data (R6)", longint'(rd_data), longint'(ref_word(r, c)));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "out_vld", longint'(out_vld), 0);
        check("R9", "row_sel", longint'(row_sel), 0);
        check("R9", "col_sel", longint'(col_sel), 0);
        check("R9", "rd_data", longint'(rd_data), 0);
        rst = 1'b0;
    endtask

    task automatic t_no_carry;
        // row 3 col 1 byte 2 + row 2 col 1 byte 4 -> row 5 col 2
        do_lookup({4'd3, 2'd1, 5'd2}, {4'd2, 2'd1, 5'd4}, "R1");
        do_lookup({4'd0, 2'd0, 5'd0}, {4'd0, 2'd0, 5'd0}, "R1");
    endtask

    task automatic t_carry;
        // byte carry ripples through column 3 into the row: row 4+1+1 = 6, col 0
        do_lookup({4'd4, 2'd3, 5'd20}, {4'd1, 2'd0, 5'd15}, "R3");
        // column overflow alone carries into row
        do_lookup({4'd7, 2'd2, 5'd0}, {4'd0, 2'd3, 5'd0}, "R3");
        // byte carry only bumps the column
        do_lookup({4'd1, 2'd1, 5'd31}, {4'd2, 2'd0, 5'd1}, "R5");
    endtask

    task automatic t_wrap;
        // last row plus carry wraps to row 0
        do_lookup({4'd15, 2'd3, 5'd31}, {4'd0, 2'd0, 5'd1}, "R4");
        do_lookup({4'd9, 2'd2, 5'd16}, {4'd6, 2'd1, 5'd16}, "R4");
    endtask

    task automatic t_byte_only;
        logic [ROWS-1:0]   row_a;
        logic [COL_W-1:0]  col_a;
        logic [DATA_W-1:0] dat_a;
        do_lookup({4'd5, 2'd2, 5'd3}, {4'd6, 2'd1, 5'd10}, "R10");
        row_a = row_sel; col_a = col_sel; dat_a = rd_data;
        do_lookup({4'd5, 2'd2, 5'd20}, {4'd6, 2'd1, 5'd7}, "R10");
        check("R10", "row_sel unchanged", longint'(row_sel), longint'(row_a));
        check("R10", "col_sel unchanged", longint'(col_sel), longint'(col_a));
        check("R10", "rd_data unchanged", longint'(rd_data), longint'(dat_a));
    endtask

    task automatic t_idle;
        logic [COL_W-1:0]  col_a;
        logic [DATA_W-1:0] dat_a;
        do_lookup({4'd10, 2'd1, 5'd0}, {4'd1, 2'd1, 5'd0}, "R8");
        col_a = col_sel; dat_a = rd_data;
        @(negedge clk);
        base_idx = {4'd3, 2'd3, 5'd9};
        ofs_idx  = {4'd8, 2'd2, 5'd30};
        @(posedge clk);
        @(negedge clk);
        check("R8", "out_vld idle", longint'(out_vld), 0);
        check("R8", "row_sel idle", longint'(row_sel), 0);
        check("R8", "col_sel held", longint'(col_sel), longint'(col_a));
        check("R8", "rd_data held", longint'(rd_data), longint'(dat_a));
    endtask

    task automatic t_back_to_back;
        logic [IDX_W-1:0] b1, o1, b2, o2, f;
        int r, c;
        b1 = {4'd2, 2'd3, 5'd17}; o1 = {4'd12, 2'd0, 5'd15};
        b2 = {4'd14, 2'd1, 5'd1}; o2 = {4'd1, 2'd2, 5'd2};
        @(negedge clk);
        base_idx = b1; ofs_idx = o1; req_vld = 1'b1;
        @(negedge clk);
        base_idx = b2; ofs_idx = o2;
        f = b1 + o1; r = int'(f[IDX_W-1:LOW_W]); c = int'(f[LOW_W-1:OFF_W]);
        check("R7", "first valid", longint'(out_vld), 1);
        check("R7", "first data", longint'(rd_data), longint'(ref_word(r, c)));
        @(negedge clk);
        req_vld = 1'b0;
        f = b2 + o2; r = int'(f[IDX_W-1:LOW_W]); c = int'(f[LOW_W-1:OFF_W]);
        check("R7", "second valid", longint'(out_vld), 1);
        check("R7", "second row", longint'(row_sel), longint'(ROWS'(1) << r));
        check("R7", "second data", longint'(rd_data), longint'(ref_word(r, c)));
        @(negedge clk);
        check("R7", "valid drops", longint'(out_vld), 0);
    endtask

    task automatic t_sweep;
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            logic [IDX_W-1:0] b, o;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[IDX_W-1:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            o = IDX_W'({lfsr[4:0], lfsr[15:10]});
            do_lookup(b, o, "R6");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_no_carry();
        t_carry();
        t_wrap();
        t_byte_only();
        t_idle();
        t_back_to_back();
        t_sweep();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule